// File: doc/BRIEF.md
# Peak-Current Phase-Shift Bridge PWM

This block drives the four gates of a phase-shifted full bridge under peak current mode control. An up-down timebase defines the switching period. One half of the cycle is counting up and the other half is counting down. The first leg is a free-running complementary pair at 50% duty. The second leg does not switch on a compare value. It switches when a digital peak-current trip arrives from an external comparator, so the phase shift between the legs follows the primary current.

Each output turns on only after a programmable dead time and turns off at once. For a fast response, a trip also pulls the affected leg-2 output low in the same cycle the synchronized edge is seen. A separate output gives a peak reference code for an external DAC. This code is the commanded reference minus a slope-compensation ramp that restarts at the start of each half cycle. Both half cycles use the same commanded reference. The period, dead time, reference and slope are loaded together at the start of every period.

Phase m counts clock cycles within a period of 2P cycles. m=0 is the cycle in which the counter is 0. The up half is m=1..P, with m=P the turning point. The down half is m=P+1..2P-1 plus m=0. P and D are the shadowed period and dead time.

Top module: `pcm_psfb_pwm`

## Requirements
- R1: The counter goes 0,1,..,P,P-1,..,1 and repeats, giving a period of 2P cycles for P of at least 2.
- R2: The leg-1 raw state is high for m=1..P and low otherwise. `l1a_o` follows the raw state and `l1b_o` follows its inverse. Each output rises only after its source has been high for D earlier consecutive cycles, and falls in the same cycle as its source.
- R3: `l1a_o` and `l1b_o` are never high together, and neither is the pair `l2a_o` and `l2b_o`.
- R4: With no trip, the leg-2 raw state is set by the turning point and cleared by the zero point. It is high for m=P+1..2P-1 and for m=0.
- R5: An accepted up-half trip in cycle t sets the leg-2 raw state from m=t+1. An accepted down-half trip in cycle t clears it from m=t+1. `l2a_o` follows the raw state and `l2b_o` its inverse, with the same dead-time rule as R2.
- R6: An accepted up-half trip forces `l2b_o` low from its own cycle through m=P. An accepted down-half trip forces `l2a_o` low from its own cycle through m=0.
- R7: `trip_async_i` goes through two flops. An edge sampled high at the end of cycle c is seen in cycle c+2. Only the first edge in a half cycle is accepted, and an edge seen at m=0 or m=P is dropped.
- R8: `pkref_o` equals max(ref - n*slope, 0), where n is the number of cycles since the last m=0 or m=P cycle. At m=1 and m=P+1, n is 0.
- R9: The period, dead time, reference and slope inputs are captured only in the m=0 cycle and take effect from m=1.
- R10: While in reset, and in the first cycle after release, all four gate outputs and `pkref_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prd_i | input | CW | Half-period P in cycles |
| dt_i | input | DTW | Dead time D in cycles |
| ref_i | input | RW | Commanded peak reference |
| slope_i | input | RW | Ramp decrement per cycle |
| trip_async_i | input | 1 | Asynchronous peak-current trip |
| l1a_o | output | 1 | Leg 1 high-side gate |
| l1b_o | output | 1 | Leg 1 low-side gate |
| l2a_o | output | 1 | Leg 2 gate A |
| l2b_o | output | 1 | Leg 2 gate B |
| pkref_o | output | RW | Peak reference code for the DAC |

## Verification
A trip line raised before the clock edge that ends cycle c produces its forcing effect in cycle c+2 and its raw-state change in cycle c+3. A gate rises D cycles after its raw state rises, and the ramp value lags the restart by one cycle. The bench drives its inputs and the trip line at the falling edge. It keeps its own phase count and samples every output at the falling edge of every cycle, so each expected value is compared in the exact cycle in which it is due.

// File: rtl/pcm_psfb_pwm.sv
module pcm_psfb_pwm #(
  parameter int CW  = 8,
  parameter int DTW = 6,
  parameter int RW  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] prd_i,
  input  logic [DTW-1:0] dt_i,
  input  logic [RW-1:0] ref_i,
  input  logic [RW-1:0] slope_i,
  input  logic          trip_async_i,
  output logic          l1a_o,
  output logic          l1b_o,
  output logic          l2a_o,
  output logic          l2b_o,
  output logic [RW-1:0] pkref_o
);
  localparam int AW = RW + CW;

  logic [CW-1:0]  cnt, prd_s;
  logic [DTW-1:0] dt_s;
  logic [RW-1:0]  ref_s, slope_s;
  logic           up, run, q1, q2, s1, s2, s3, tz_up, tz_dn;
  logic [AW-1:0]  ramp;
  logic [3:0]     raw, chan;

  wire zero_ev = (cnt == '0);
  wire prd_ev  = up && !zero_ev && (cnt >= prd_s);
  wire trip_ev = s2 && !s3;
  wire free    = !(tz_up || tz_dn) && !zero_ev && !prd_ev;
  wire hit_up  = trip_ev && free && up;
  wire hit_dn  = trip_ev && free && !up;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; up <= 1'b0; run <= 1'b0;
      prd_s <= '0; dt_s <= '0; ref_s <= '0; slope_s <= '0;
    end else begin
      run <= 1'b1;
      if (zero_ev) begin
        cnt <= CW'(1); up <= 1'b1;
        prd_s <= prd_i; dt_s <= dt_i; ref_s <= ref_i; slope_s <= slope_i;
      end else if (prd_ev) begin
        cnt <= cnt - 1'b1; up <= 1'b0;
      end else if (up) cnt <= cnt + 1'b1;
      else             cnt <= cnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      q1 <= 1'b0; q2 <= 1'b0; tz_up <= 1'b0; tz_dn <= 1'b0;
    end else begin
      s1 <= trip_async_i; s2 <= s1; s3 <= s2;
      if (zero_ev || prd_ev) begin
        q1 <= zero_ev; q2 <= prd_ev;
        tz_up <= 1'b0; tz_dn <= 1'b0;
      end else begin
        if (hit_up) begin q2 <= 1'b1; tz_up <= 1'b1; end
        if (hit_dn) begin q2 <= 1'b0; tz_dn <= 1'b1; end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  ramp <= '0;
    else if (zero_ev || prd_ev)  ramp <= '0;
    else                         ramp <= ramp + AW'(slope_s);

  assign pkref_o = (ramp >= AW'(ref_s)) ? '0 : ref_s - ramp[RW-1:0];

  assign raw = {~q2, q2, ~q1, q1};

  for (genvar i = 0; i < 4; i++) begin : g_dead
    logic [DTW-1:0] held;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          held <= '0;
      else if (!raw[i])    held <= '0;
      else if (held != '1) held <= held + 1'b1;
    assign chan[i] = raw[i] && (held >= dt_s);
  end

  assign l1a_o = run && chan[0];
  assign l1b_o = run && chan[1];
  assign l2a_o = run && chan[2] && !(hit_dn || tz_dn);
  assign l2b_o = run && chan[3] && !(hit_up || tz_up);

  a_r3_leg1_excl: assert property (@(posedge clk) disable iff (!rst_n) !(l1a_o && l1b_o));
  a_r3_leg2_excl: assert property (@(posedge clk) disable iff (!rst_n) !(l2a_o && l2b_o));
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n) (prd_s != '0) |-> (cnt <= prd_s));
  a_r4_prd_sets:  assert property (@(posedge clk) disable iff (!rst_n) prd_ev |=> q2);
  a_r4_zero_clr:  assert property (@(posedge clk) disable iff (!rst_n) zero_ev |=> !q2);
  a_r5_up_sets:   assert property (@(posedge clk) disable iff (!rst_n) hit_up |=> q2);
  a_r8_ramp_rst:  assert property (@(posedge clk) disable iff (!rst_n) (zero_ev || prd_ev) |=> (ramp == '0));
  a_r9_shadow:    assert property (@(posedge clk) disable iff (!rst_n) !zero_ev |=> ($stable(prd_s) && $stable(ref_s) && $stable(dt_s)));
endmodule

// File: tb/sim_pcm_psfb_pwm.sv
module sim_pcm_psfb_pwm;
  localparam int CW = 8, DTW = 6, RW = 10;
  logic clk = 1'b0, rst_n = 1'b0, trip = 1'b0;
  logic [CW-1:0] prd = '0;
  logic [DTW-1:0] dt = '0;
  logic [RW-1:0] rf = '0, sl = '0;
  logic l1a, l1b, l2a, l2b;
  logic [RW-1:0] pk;
  int checks = 0, fails = 0;
  bit done = 0;
  int ph, cP, cD, cR, cS;
  bit first, q1e, q2e, fu, fd;
  int r[4];
  int tu = -1, tu2 = -1, td = -1, td2 = -1;

  always #2 clk = ~clk;

  pcm_psfb_pwm #(.CW(CW), .DTW(DTW), .RW(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .prd_i(prd), .dt_i(dt), .ref_i(rf), .slope_i(sl),
    .trip_async_i(trip), .l1a_o(l1a), .l1b_o(l1b), .l2a_o(l2a), .l2b_o(l2b), .pkref_o(pk));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; trip = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 l1a", l1a, 0); chk("R10 l1b", l1b, 0);
    chk("R10 l2a", l2a, 0); chk("R10 l2b", l2b, 0); chk("R10 pkref", pk, 0);
    rst_n = 1'b1;
    ph = 0; cP = 0; cD = 0; cR = 0; cS = 0; first = 1;
    q1e = 0; q2e = 0; fu = 0; fd = 0;
    for (int i = 0; i < 4; i++) r[i] = 0;
  endtask

  task automatic step(int n);
    for (int c = 0; c < n; c++) begin
      bit rq[4];
      bit oe[4];
      bit fA, fB, run;
      int e, k;
      rq[0] = q1e; rq[1] = !q1e; rq[2] = q2e; rq[3] = !q2e;
      for (int i = 0; i < 4; i++) oe[i] = rq[i] && (r[i] >= cD);
      fB = fu || (ph == tu);
      fA = fd || (ph == td);
      run = !first;
      chk("R2 l1a", l1a, run && oe[0]);
      chk("R2 l1b", l1b, run && oe[1]);
      chk("R5/R6 l2a", l2a, run && oe[2] && !fA);
      chk("R5/R6 l2b", l2b, run && oe[3] && !fB);
      chk("R3 exclusive", (l1a && l1b) || (l2a && l2b), 0);
      if (first) e = 0;
      else begin
        if (ph >= 1 && ph <= cP) k = ph - 1;
        else if (ph == 0) k = cP - 1;
        else k = ph - cP - 1;
        e = cR - k * cS;
        if (e < 0) e = 0;
      end
      chk("R8 pkref", pk, e);
      if (ph == 0) begin q1e = 1; q2e = 0; fu = 0; fd = 0; end
      else if (ph == cP) begin q1e = 0; q2e = 1; fu = 0; fd = 0; end
      else begin
        if (ph == tu) begin q2e = 1; fu = 1; end
        if (ph == td) begin q2e = 0; fd = 1; end
      end
      for (int i = 0; i < 4; i++) r[i] = rq[i] ? ((r[i] < 1000) ? r[i] + 1 : r[i]) : 0;
      if (ph == tu - 2 || ph == tu2 - 2 || ph == td - 2 || ph == td2 - 2) trip = 1'b1;
      else if (ph == tu || ph == tu2 || ph == td || ph == td2) trip = 1'b0;
      if (ph == 0) begin cP = prd; cD = dt; cR = rf; cS = sl; first = 0; end
      ph = ph + 1;
      if (ph >= 2 * cP) ph = 0;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 R2 R4 R8: free run, ramp saturates at zero
    prd = 6; dt = 2; rf = 200; sl = 45; tu = -1; tu2 = -1; td = -1; td2 = -1;
    do_reset(); step(60);
    // R5 R6 R7: one trip per half
    prd = 8; dt = 1; rf = 100; sl = 7; tu = 4; td = 13;
    do_reset(); step(80);
    // R7: second edges in a half are ignored, earliest trips
    prd = 10; dt = 3; rf = 1000; sl = 0; tu = 2; tu2 = 6; td = 12; td2 = 17;
    do_reset(); step(100);
    // zero dead time, up-half trip only
    prd = 5; dt = 0; rf = 50; sl = 1; tu = 3; tu2 = -1; td = -1; td2 = -1;
    do_reset(); step(40);
    // dead time longer than a half: gates stay off
    prd = 4; dt = 6; rf = 20; sl = 3; tu = -1;
    do_reset(); step(30);
    // R9: mid-period change applies only after the next zero point
    prd = 6; dt = 1; rf = 300; sl = 10;
    do_reset(); step(15);
    prd = 9; dt = 4; rf = 500; sl = 20;
    step(60);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule